// File: doc/BRIEF.md
# Conditional Execution Evaluator

This unit decides, for one instruction at a time, whether that instruction is allowed to execute. It reads a four-bit condition code and the four status flags, negative, zero, carry and overflow. It returns a registered pass/fail decision and the fall-through program counter, which is the current PC advanced by one instruction. The unit handles two encodings, selected by a state input. In wide (32-bit) state the condition is taken from the top nibble of the opcode. In narrow (16-bit) state only the conditional-branch group is tested, and every other narrow instruction passes unconditionally.

A caller raises `in_valid` for one cycle with the opcode, the status word, the current PC and the state. One cycle later `out_valid` is high and `exec_pass` and `next_pc` hold the result. When no strobe arrives, the results stay as they were. A two-state controller tracks whether a result is being presented. Its states are ST_IDLE and ST_RESULT. A strobe moves it from either state to ST_RESULT. A cycle without a strobe moves it from either state to ST_IDLE. Reset puts it in ST_IDLE.

Top module: `cond_eval_unit`

## Requirements
- R1: While `rst_n` is low and after reset, until the first strobe, `out_valid`, `exec_pass` and `next_pc` are all zero.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `exec_pass` and `next_pc` keep their values across cycles without a strobe.
- R3: In wide state (`narrow_mode`=0) the condition code is opcode bits 31:28. In narrow state it is opcode bits 11:8, and it is only applied when opcode bits 15:12 equal 4'hD.
- R4: The flags are read from `status_word` bit 31 (N), bit 30 (Z), bit 29 (C) and bit 28 (V). Bits 27:0 have no effect on the result.
- R5: Codes 0 to 7 pass when, in order: Z=1, Z=0, C=1, C=0, N=1, N=0, V=1, V=0.
- R6: Code 8 passes when C=1 and Z=0. Code 9 passes when C=0 or Z=1.
- R7: Code 10 passes when N equals V. Code 11 passes when N differs from V.
- R8: Code 12 passes when Z=0 and N equals V. Code 13 passes when Z=1 or N differs from V.
- R9: Codes 14 and 15 always pass.
- R10: In narrow state, an opcode whose bits 15:12 are not 4'hD always passes, whatever bits 11:8 and the flags hold.
- R11: `next_pc` is `cur_pc`+4 in wide state and `cur_pc`+2 in narrow state, wrapping modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | One-cycle strobe: evaluate the presented instruction |
| narrow_mode | input | 1 | 1 = 16-bit instruction state, 0 = 32-bit state |
| opcode | input | 32 | Instruction word (narrow state uses bits 15:0) |
| status_word | input | 32 | Status register; flags in bits 31:28 |
| cur_pc | input | 32 | Address of the instruction |
| out_valid | output | 1 | Result presented this cycle |
| exec_pass | output | 1 | 1 = instruction executes |
| next_pc | output | 32 | Fall-through address |

## Verification
The bench sweeps all sixteen codes against all sixteen flag combinations in both encodings. This catches a design that confuses the N/V-based pairs with the C/Z-based pairs, or that inverts the wrong half of a code pair. Narrow opcodes outside the branch group carry bits 11:8 and flags that would fail if tested. A design that tests every narrow instruction, or that reads the condition from the wrong nibble, reports a failure there. The PC step is checked at the top of the address space, where a design that does not wrap, or that uses the wrong instruction size, gives the wrong fall-through address. Idle cycles with changed inputs expose a design that updates its result without a strobe.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

    typedef struct packed {
        logic neg;
        logic zero;
        logic carry;
        logic ovf;
    } nzcv_t;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } eval_state_e;

    localparam logic [3:0] NARROW_BRANCH_GROUP = 4'hD;

endpackage

// File: rtl/cond_field_select.sv
module cond_field_select #(
    parameter int OPW = 32
) (
    input  logic           narrow_mode,
    input  logic [OPW-1:0] opcode,
    output logic [3:0]     cond_code,
    output logic           cond_applies
);
    import cond_eval_pkg::*;

    localparam int WIDE_LSB = OPW - 4;

    logic unused_opcode_bits;
    assign unused_opcode_bits = ^{opcode[WIDE_LSB-1:16], opcode[7:0]};

    always_comb begin
        if (narrow_mode) begin
            cond_code    = opcode[11:8];
            cond_applies = (opcode[15:12] == NARROW_BRANCH_GROUP);
        end else begin
            cond_code    = opcode[OPW-1:WIDE_LSB];
            cond_applies = 1'b1;
        end
    end

endmodule

// File: rtl/cond_flag_test.sv
module cond_flag_test (
    input  logic                 enable,
    input  logic [3:0]           cond_code,
    input  cond_eval_pkg::nzcv_t flags,
    output logic                 pass
);
    logic base;
    logic n_eq_v;

    assign n_eq_v = (flags.neg == flags.ovf);

    // Codes come in pairs; the odd member is the complement of the even one.
    always_comb begin
        unique case (cond_code[3:1])
            3'd0: base = flags.zero;
            3'd1: base = flags.carry;
            3'd2: base = flags.neg;
            3'd3: base = flags.ovf;
            3'd4: base = flags.carry & ~flags.zero;
            3'd5: base = n_eq_v;
            3'd6: base = ~flags.zero & n_eq_v;
            default: base = 1'b1;
        endcase
        if (!enable || cond_code[3:1] == 3'd7) begin
            pass = 1'b1;
        end else begin
            pass = base ^ cond_code[0];
        end
    end

endmodule

// File: rtl/cond_eval_unit.sv
module cond_eval_unit #(
    parameter int XLEN         = 32,
    parameter int WIDE_BYTES   = 4,
    parameter int NARROW_BYTES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            narrow_mode,
    input  logic [XLEN-1:0] opcode,
    input  logic [XLEN-1:0] status_word,
    input  logic [XLEN-1:0] cur_pc,
    output logic            out_valid,
    output logic            exec_pass,
    output logic [XLEN-1:0] next_pc
);
    import cond_eval_pkg::*;

    localparam logic [XLEN-1:0] WIDE_STEP   = XLEN'(WIDE_BYTES);
    localparam logic [XLEN-1:0] NARROW_STEP = XLEN'(NARROW_BYTES);

    eval_state_e st_q, st_d;
    logic [3:0]  cond_code;
    logic        cond_applies;
    logic        pass_c;
    nzcv_t       flags;
    logic [XLEN-1:0] step_c;
    logic            unused_status_bits;

    assign flags              = status_word[XLEN-1:XLEN-4];
    assign unused_status_bits = ^status_word[XLEN-5:0];
    assign step_c             = narrow_mode ? NARROW_STEP : WIDE_STEP;

    cond_field_select #(.OPW(XLEN)) u_sel (
        .narrow_mode (narrow_mode),
        .opcode      (opcode),
        .cond_code   (cond_code),
        .cond_applies(cond_applies)
    );

    cond_flag_test u_test (
        .enable   (cond_applies),
        .cond_code(cond_code),
        .flags    (flags),
        .pass     (pass_c)
    );

    always_comb begin
        unique case (st_q)
            ST_IDLE:   st_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: st_d = in_valid ? ST_RESULT : ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exec_pass <= 1'b0;
            next_pc   <= '0;
        end else if (in_valid) begin
            exec_pass <= pass_c;
            next_pc   <= cur_pc + step_c;
        end
    end

    assign out_valid = (st_q == ST_RESULT);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(exec_pass) && $stable(next_pc))); // R2
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (next_pc == $past(cur_pc) + ($past(narrow_mode) ? NARROW_STEP : WIDE_STEP))); // R11
    AST_ALWAYS_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !narrow_mode && opcode[XLEN-1:XLEN-3] == 3'b111) |=> exec_pass); // R9
    AST_NARROW_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && narrow_mode && opcode[15:12] != NARROW_BRANCH_GROUP) |=> exec_pass); // R10

endmodule

// File: tb/sim_cond_eval_unit.sv
`timescale 1ns/100ps
module sim_cond_eval_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        narrow_mode = 1'b0;
    logic [31:0] opcode = '0;
    logic [31:0] status_word = '0;
    logic [31:0] cur_pc = '0;
    logic        out_valid;
    logic        exec_pass;
    logic [31:0] next_pc;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    cond_eval_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .narrow_mode(narrow_mode),
        .opcode(opcode), .status_word(status_word), .cur_pc(cur_pc),
        .out_valid(out_valid), .exec_pass(exec_pass), .next_pc(next_pc)
    );

    function automatic logic ref_pass(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return cy;
            4'd3:  return !cy;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return cy && !z;
            4'd9:  return !cy || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Strobe one instruction, then sample the registered result at the next falling edge.
    task automatic evaluate(input logic nm, input logic [31:0] op, input logic [31:0] sw,
                            input logic [31:0] pc);
        @(negedge clk);
        narrow_mode = nm; opcode = op; status_word = sw; cur_pc = pc; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        #1;
        check("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
        check("R1 exec_pass after reset", {31'd0, exec_pass}, 32'd0);
        check("R1 next_pc after reset", next_pc, 32'd0);
    endtask

    task automatic t_wide_sweep;
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                evaluate(1'b0, {c[3:0], 28'h1A2B3C4}, {f[3:0], 28'h0}, 32'h0000_1000);
                check("R2 out_valid after strobe", {31'd0, out_valid}, 32'd1);
                // R3 R5 R6 R7 R8 R9: condition from bits 31:28
                check("R3/R5-R9 wide pass", {31'd0, exec_pass}, {31'd0, ref_pass(c[3:0], f[3:0])});
            end
        end
        check("R11 wide step", next_pc, 32'h0000_1004);
    endtask

    task automatic t_narrow_branch;
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                // high half holds code 14 so a wrong nibble choice would always pass
                evaluate(1'b1, {16'hE000, 4'hD, c[3:0], 8'h5A}, {f[3:0], 28'h0}, 32'h0000_2000);
                check("R3 narrow branch pass", {31'd0, exec_pass}, {31'd0, ref_pass(c[3:0], f[3:0])});
            end
        end
        check("R11 narrow step", next_pc, 32'h0000_2002);
    endtask

    task automatic t_narrow_other;
        // code 0 in bits 11:8 with Z clear would fail if tested
        for (int g = 0; g < 16; g++) begin
            if (g == 13) continue;
            evaluate(1'b1, {16'h0000, g[3:0], 4'h0, 8'h00}, 32'h0000_0000, 32'h0000_3000);
            check("R10 narrow non-branch passes", {31'd0, exec_pass}, 32'd1);
        end
    endtask

    task automatic t_low_status_bits;
        evaluate(1'b0, 32'h0000_0000, 32'h0FFF_FFFF, 32'h0);
        check("R4 low status bits ignored (EQ, Z=0)", {31'd0, exec_pass}, 32'd0);
        evaluate(1'b0, 32'h1000_0000, 32'h4000_0000, 32'h0);
        check("R4 Z from bit 30 (NE)", {31'd0, exec_pass}, 32'd0);
        evaluate(1'b0, 32'h4000_0000, 32'h8000_0000, 32'h0);
        check("R4 N from bit 31", {31'd0, exec_pass}, 32'd1);
    endtask

    task automatic t_pc_wrap;
        evaluate(1'b0, 32'hE000_0000, 32'h0, 32'hFFFF_FFFE);
        check("R11 wide wrap", next_pc, 32'h0000_0002);
        evaluate(1'b1, 32'h0000_0000, 32'h0, 32'hFFFF_FFFF);
        check("R11 narrow wrap", next_pc, 32'h0000_0001);
    endtask

    task automatic t_hold;
        evaluate(1'b0, 32'h0000_0000, 32'h0000_0000, 32'h0000_0100); // fails
        @(negedge clk);
        narrow_mode = 1'b1; opcode = 32'hE000_0000; status_word = 32'hF000_0000; cur_pc = 32'h5555_0000;
        @(negedge clk);
        @(negedge clk);
        check("R2 out_valid low when idle", {31'd0, out_valid}, 32'd0);
        check("R2 exec_pass held", {31'd0, exec_pass}, 32'd0);
        check("R2 next_pc held", next_pc, 32'h0000_0104);
    endtask

    initial begin
        t_reset;
        t_wide_sweep;
        t_narrow_branch;
        t_narrow_other;
        t_low_status_bits;
        t_pc_wrap;
        t_hold;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule